// File: doc/BRIEF.md
# Integer Move, Multiply and Logic Execute Unit

This unit is the execute stage for a group of register-to-register operations in a 32-bit integer pipeline. A decoder presents an operation code, the values of the two source registers and the immediate fields of the instruction, together with a one-cycle valid strobe. One clock edge later the unit presents the destination-register value, a write enable for that register, and, for the logic operations, a new overflow/sign/zero flag set with its own write enable.

The operation group covers register and short-immediate moves, an address add with a sign-extended 16-bit offset, an add of a 16-bit value placed in the upper half-word, three signed half-word multiplies, bitwise complement, bitwise OR, and a no-op. The operand called `src1_i` is the first source register; `src2_i` is the current value of the second register, which is also the destination. Only the complement and OR operations change flags. The unit holds the flag state it last wrote so that the flag outputs always show the current flags.

Top module: `exu_mov_mul_logic`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `rd_we_o` and `flag_we_o` are 0, `result_o` is 0, and all three flag outputs are 0.
- R2: `valid_o` is 1 in the cycle after a cycle with `valid_i` = 1 and 0 otherwise; `rd_we_o` and `flag_we_o` are never 1 while `valid_o` is 0.
- R3: Code 1 (register move) writes `src1_i`; code 2 (short immediate move) writes `imm5_i` sign-extended from bit 4 to 32 bits.
- R4: Code 3 (address add) writes `src1_i` plus `imm16_i` sign-extended from bit 15, modulo 2^32.
- R5: Code 4 (high add) writes `src1_i` plus the word with `imm16_i` in bits 31:16 and zeros in bits 15:0, modulo 2^32.
- R6: Code 5 (register multiply) writes the 32-bit signed product of `src2_i[15:0]` and `src1_i[15:0]`; bits 31:16 of both sources have no effect.
- R7: Code 6 (short immediate multiply) writes the signed product of `src2_i[15:0]` and `imm5_i` sign-extended from bit 4.
- R8: Code 7 (long immediate multiply) writes the signed product of `src1_i[15:0]` and `imm16_i`, both taken as signed 16-bit values.
- R9: Code 8 writes the one's complement of `src1_i`; code 9 writes `src1_i | src2_i`. Both assert `flag_we_o`, set `flag_ov_o` to 0, `flag_s_o` to result bit 31 and `flag_z_o` to 1 exactly when the result is zero.
- R10: Codes 1 to 7 assert `rd_we_o`, keep `flag_we_o` at 0 and leave the three flag outputs unchanged.
- R11: Code 0 (no-op) and the unused codes 10 to 15 complete with `valid_o` = 1 but keep `rd_we_o` and `flag_we_o` at 0 and leave `result_o` and the flags unchanged.
- R12: In a cycle after one without `valid_i`, `result_o` and the flags hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe, one cycle per operation |
| op_i | input | 4 | Operation code |
| src1_i | input | 32 | First source register value |
| src2_i | input | 32 | Second source / destination register value |
| imm5_i | input | 5 | Short immediate field |
| imm16_i | input | 16 | Long immediate field |
| result_o | output | 32 | Destination register value |
| rd_we_o | output | 1 | Destination register write enable |
| valid_o | output | 1 | Operation completed |
| flag_we_o | output | 1 | Flag write enable |
| flag_ov_o | output | 1 | Overflow flag |
| flag_s_o | output | 1 | Sign flag |
| flag_z_o | output | 1 | Zero flag |

## Verification
Every result, write enable and flag change is due exactly one clock edge after the edge that captures `valid_i`; nothing in the unit takes longer, including the multiplies. The bench drives each operation on a falling edge, lets one rising edge pass, and samples every output on the next falling edge, then drops the strobe and samples once more a cycle later to confirm that the strobes fell and that the result and flags held. Flag persistence is checked by running moves and multiplies after a logic operation and comparing the flag outputs with the values that operation left.

// File: rtl/exu_mml_pkg.sv
`timescale 1ns/1ps
package exu_mml_pkg;

  localparam int unsigned XLEN  = 32;
  localparam int unsigned OP_W  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP     = 4'd0,
    OP_MOV_R   = 4'd1,
    OP_MOV_I5  = 4'd2,
    OP_ADDR    = 4'd3,
    OP_HIADD   = 4'd4,
    OP_MUL_R   = 4'd5,
    OP_MUL_I5  = 4'd6,
    OP_MUL_I16 = 4'd7,
    OP_NOT     = 4'd8,
    OP_OR      = 4'd9
  } exu_op_e;

  typedef struct packed {
    logic ov;
    logic s;
    logic z;
  } exu_flags_t;

  typedef enum logic [1:0] {
    RES_ADD,
    RES_MUL,
    RES_LOGIC,
    RES_MOVE
  } exu_res_sel_e;

  typedef struct packed {
    logic         rd_we;
    logic         flag_we;
    exu_res_sel_e res_sel;
  } exu_ctrl_t;

  function automatic exu_ctrl_t decode_op(input logic [OP_W-1:0] op);
    exu_ctrl_t c;
    c = '{rd_we: 1'b0, flag_we: 1'b0, res_sel: RES_MOVE};
    unique case (op)
      OP_MOV_R, OP_MOV_I5:            c = '{rd_we: 1'b1, flag_we: 1'b0, res_sel: RES_MOVE};
      OP_ADDR, OP_HIADD:              c = '{rd_we: 1'b1, flag_we: 1'b0, res_sel: RES_ADD};
      OP_MUL_R, OP_MUL_I5, OP_MUL_I16: c = '{rd_we: 1'b1, flag_we: 1'b0, res_sel: RES_MUL};
      OP_NOT, OP_OR:                  c = '{rd_we: 1'b1, flag_we: 1'b1, res_sel: RES_LOGIC};
      default:                        c = '{rd_we: 1'b0, flag_we: 1'b0, res_sel: RES_MOVE};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/exu_sext.sv
`timescale 1ns/1ps
module exu_sext #(
  parameter int unsigned IN_W  = 5,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);

  localparam int unsigned PAD_W = (OUT_W > IN_W) ? OUT_W - IN_W : 1;

  generate
    if (OUT_W > IN_W) begin : g_extend
      assign val_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
    end else begin : g_pass
      assign val_o = val_i[OUT_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/exu_addr_unit.sv
`timescale 1ns/1ps
module exu_addr_unit #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             hi_sel_i,
  output logic [XLEN-1:0]  sum_o
);

  localparam int unsigned LO_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_sext;
  logic [XLEN-1:0] imm_high;
  logic [XLEN-1:0] addend;

  exu_sext #(.IN_W(IMM_W), .OUT_W(XLEN)) u_sext (
    .val_i (imm_i),
    .val_o (imm_sext)
  );

  assign imm_high = {imm_i, {LO_W{1'b0}}};
  assign addend   = hi_sel_i ? imm_high : imm_sext;
  assign sum_o    = base_i + addend;

endmodule

// File: rtl/exu_hmul.sv
`timescale 1ns/1ps
module exu_hmul #(
  parameter int unsigned HALF = 16
) (
  input  logic [HALF-1:0]   a_i,
  input  logic [HALF-1:0]   b_i,
  output logic [2*HALF-1:0] prod_o
);

  localparam int unsigned PW = 2 * HALF;

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;

  // widen first so the low PW bits carry the full signed product
  assign a_ext  = $signed({{HALF{a_i[HALF-1]}}, a_i});
  assign b_ext  = $signed({{HALF{b_i[HALF-1]}}, b_i});
  assign prod_o = a_ext * b_ext;

endmodule

// File: rtl/exu_logic_unit.sv
`timescale 1ns/1ps
module exu_logic_unit
  import exu_mml_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            inv_sel_i,
  output logic [XLEN-1:0] res_o,
  output exu_flags_t      flags_o
);

  always_comb begin
    res_o      = inv_sel_i ? ~a_i : (a_i | b_i);
    flags_o.ov = 1'b0;
    flags_o.s  = res_o[XLEN-1];
    flags_o.z  = ~|res_o;
  end

endmodule

// File: rtl/exu_mov_mul_logic.sv
`timescale 1ns/1ps
module exu_mov_mul_logic
  import exu_mml_pkg::*;
#(
  parameter int unsigned XW     = 32,
  parameter int unsigned IMM_SW = 5,
  parameter int unsigned IMM_LW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [XW-1:0]     src1_i,
  input  logic [XW-1:0]     src2_i,
  input  logic [IMM_SW-1:0] imm5_i,
  input  logic [IMM_LW-1:0] imm16_i,
  output logic [XW-1:0]     result_o,
  output logic              rd_we_o,
  output logic              valid_o,
  output logic              flag_we_o,
  output logic              flag_ov_o,
  output logic              flag_s_o,
  output logic              flag_z_o
);

  localparam int unsigned HALF = XW / 2;

  exu_op_e    op;
  exu_ctrl_t  ctrl;

  logic [XW-1:0]   imm5_word;
  logic [HALF-1:0] imm5_half;
  logic [XW-1:0]   add_res;
  logic [HALF-1:0] mul_a;
  logic [HALF-1:0] mul_b;
  logic [XW-1:0]   mul_res;
  logic [XW-1:0]   log_res;
  exu_flags_t      log_flags;
  logic [XW-1:0]   mov_res;
  logic [XW-1:0]   res_d;

  logic [XW-1:0]   result_q;
  logic            rd_we_q;
  logic            valid_q;
  logic            flag_we_q;
  exu_flags_t      flags_q;

  assign op   = exu_op_e'(op_i);
  assign ctrl = decode_op(op_i);

  exu_sext #(.IN_W(IMM_SW), .OUT_W(XW)) u_sext_word (
    .val_i (imm5_i),
    .val_o (imm5_word)
  );

  exu_sext #(.IN_W(IMM_SW), .OUT_W(HALF)) u_sext_half (
    .val_i (imm5_i),
    .val_o (imm5_half)
  );

  exu_addr_unit #(.XLEN(XW), .IMM_W(IMM_LW)) u_addr (
    .base_i   (src1_i),
    .imm_i    (imm16_i),
    .hi_sel_i (op == OP_HIADD),
    .sum_o    (add_res)
  );

  // multiplicand/multiplier selection per multiply form
  always_comb begin
    unique case (op)
      OP_MUL_I5: begin
        mul_a = src2_i[HALF-1:0];
        mul_b = imm5_half;
      end
      OP_MUL_I16: begin
        mul_a = src1_i[HALF-1:0];
        mul_b = imm16_i[HALF-1:0];
      end
      default: begin
        mul_a = src2_i[HALF-1:0];
        mul_b = src1_i[HALF-1:0];
      end
    endcase
  end

  exu_hmul #(.HALF(HALF)) u_mul (
    .a_i    (mul_a),
    .b_i    (mul_b),
    .prod_o (mul_res)
  );

  exu_logic_unit #(.XLEN(XW)) u_logic (
    .a_i       (src1_i),
    .b_i       (src2_i),
    .inv_sel_i (op == OP_NOT),
    .res_o     (log_res),
    .flags_o   (log_flags)
  );

  assign mov_res = (op == OP_MOV_I5) ? imm5_word : src1_i;

  always_comb begin
    unique case (ctrl.res_sel)
      RES_ADD:   res_d = add_res;
      RES_MUL:   res_d = mul_res;
      RES_LOGIC: res_d = log_res;
      default:   res_d = mov_res;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      rd_we_q   <= 1'b0;
      flag_we_q <= 1'b0;
    end else begin
      valid_q   <= valid_i;
      rd_we_q   <= valid_i & ctrl.rd_we;
      flag_we_q <= valid_i & ctrl.flag_we;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
    end else if (valid_i && ctrl.rd_we) begin
      result_q <= res_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (valid_i && ctrl.flag_we) begin
      flags_q <= log_flags;
    end
  end

  assign result_o  = result_q;
  assign rd_we_o   = rd_we_q;
  assign valid_o   = valid_q;
  assign flag_we_o = flag_we_q;
  assign flag_ov_o = flags_q.ov;
  assign flag_s_o  = flags_q.s;
  assign flag_z_o  = flags_q.z;

endmodule

// File: rtl/exu_mml_checker.sv
`timescale 1ns/1ps
module exu_mml_checker #(
  parameter int unsigned XW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [3:0]    op_i,
  input logic [XW-1:0] result_o,
  input logic          rd_we_o,
  input logic          valid_o,
  input logic          flag_we_o,
  input logic          flag_ov_o,
  input logic          flag_s_o,
  input logic          flag_z_o
);

  logic mov_mul_op;
  logic no_write_op;
  assign mov_mul_op  = (op_i >= 4'd1) && (op_i <= 4'd7);
  assign no_write_op = (op_i == 4'd0) || (op_i >= 4'd10);

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r2_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  a_r2_enables_inside_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_we_o || flag_we_o) |-> valid_o);

  a_r9_flags_match_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> (!flag_ov_o && (flag_s_o == result_o[XW-1]) && (flag_z_o == (result_o == '0))));

  a_r10_flags_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mov_mul_op) |=> (rd_we_o && !flag_we_o && $stable(flag_ov_o)
                                 && $stable(flag_s_o) && $stable(flag_z_o)));

  a_r11_nop_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && no_write_op) |=> (!rd_we_o && !flag_we_o && $stable(result_o)));

  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(flag_s_o) && $stable(flag_z_o)));

endmodule

bind exu_mov_mul_logic exu_mml_checker #(.XW(XW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .result_o  (result_o),
  .rd_we_o   (rd_we_o),
  .valid_o   (valid_o),
  .flag_we_o (flag_we_o),
  .flag_ov_o (flag_ov_o),
  .flag_s_o  (flag_s_o),
  .flag_z_o  (flag_z_o)
);

// File: tb/exu_mov_mul_logic_test.sv
`timescale 1ns/1ps
module exu_mov_mul_logic_test;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] src1_i = '0;
  logic [31:0] src2_i = '0;
  logic [4:0]  imm5_i = '0;
  logic [15:0] imm16_i = '0;
  logic [31:0] result_o;
  logic        rd_we_o, valid_o, flag_we_o, flag_ov_o, flag_s_o, flag_z_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state: flags the unit should currently hold
  logic exp_ov = 1'b0, exp_s = 1'b0, exp_z = 1'b0;
  logic [31:0] last_res = '0;

  always #2.5 clk = ~clk;

  exu_mov_mul_logic uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .src1_i(src1_i), .src2_i(src2_i), .imm5_i(imm5_i), .imm16_i(imm16_i),
    .result_o(result_o), .rd_we_o(rd_we_o), .valid_o(valid_o), .flag_we_o(flag_we_o),
    .flag_ov_o(flag_ov_o), .flag_s_o(flag_s_o), .flag_z_o(flag_z_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic ov, input logic s, input logic z);
    chk(req, {29'd0, flag_ov_o, flag_s_o, flag_z_o}, {29'd0, ov, s, z});
  endtask

  // drive on falling edge, sample on the next falling edge (one rising edge later)
  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] i5, input logic [15:0] i16);
    @(negedge clk);
    op_i = op; src1_i = a; src2_i = b; imm5_i = i5; imm16_i = i16; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // write op without flags: result, enables, flags unchanged
  task automatic run_write(input string req, input logic [3:0] op, input logic [31:0] a,
                           input logic [31:0] b, input logic [4:0] i5, input logic [15:0] i16,
                           input logic [31:0] exp);
    issue(op, a, b, i5, i16);
    chk(req, result_o, exp);
    chk({req, " R10 we"}, {30'd0, rd_we_o, flag_we_o}, {30'd0, 1'b1, 1'b0});
    chk({req, " R2 valid"}, {31'd0, valid_o}, 32'd1);
    chk_flags({req, " R10 flags"}, exp_ov, exp_s, exp_z);
    last_res = exp;
  endtask

  task automatic run_logic(input string req, input logic [3:0] op, input logic [31:0] a,
                           input logic [31:0] b, input logic [31:0] exp);
    issue(op, a, b, 5'd0, 16'd0);
    chk(req, result_o, exp);
    chk({req, " R9 we"}, {30'd0, rd_we_o, flag_we_o}, {30'd0, 1'b1, 1'b1});
    exp_ov = 1'b0; exp_s = exp[31]; exp_z = (exp == 32'd0);
    chk_flags({req, " R9 flags"}, exp_ov, exp_s, exp_z);
    last_res = exp;
  endtask

  task automatic t_reset;
    chk("R1 result", result_o, 32'd0);
    chk("R1 strobes", {29'd0, valid_o, rd_we_o, flag_we_o}, 32'd0);
    chk_flags("R1 flags", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_moves;
    run_write("R3 mov reg", 4'd1, 32'hDEAD_BEEF, 32'h1111_1111, 5'd0, 16'd0, 32'hDEAD_BEEF);
    run_write("R3 mov imm neg", 4'd2, 32'h1234_5678, 32'd0, 5'h1F, 16'd0, 32'hFFFF_FFFF);
    run_write("R3 mov imm pos", 4'd2, 32'h0, 32'd0, 5'h0F, 16'd0, 32'h0000_000F);
    run_write("R3 mov imm min", 4'd2, 32'h0, 32'd0, 5'h10, 16'd0, 32'hFFFF_FFF0);
  endtask

  task automatic t_adds;
    run_write("R4 addr neg", 4'd3, 32'h0000_1000, 32'd0, 5'd0, 16'hFFF0, 32'h0000_0FF0);
    run_write("R4 addr wrap", 4'd3, 32'hFFFF_FFFF, 32'd0, 5'd0, 16'h0001, 32'h0000_0000);
    run_write("R4 addr pos", 4'd3, 32'h0000_0010, 32'd0, 5'd0, 16'h7FFF, 32'h0000_800F);
    run_write("R5 hi add", 4'd4, 32'h0000_1234, 32'd0, 5'd0, 16'hABCD, 32'hABCD_1234);
    run_write("R5 hi carry", 4'd4, 32'hFFFF_0001, 32'd0, 5'd0, 16'h0002, 32'h0001_0001);
  endtask

  task automatic t_muls;
    run_write("R6 mul reg neg", 4'd5, 32'h0000_FFFF, 32'h0000_0002, 5'd0, 16'd0, 32'hFFFF_FFFE);
    run_write("R6 mul reg upper ignored", 4'd5, 32'h7FFF_8000, 32'h1234_8000, 5'd0, 16'd0,
              32'h4000_0000);
    run_write("R6 mul reg max", 4'd5, 32'h0000_7FFF, 32'hFFFF_7FFF, 5'd0, 16'd0, 32'h3FFF_0001);
    run_write("R7 mul imm5 neg", 4'd6, 32'hFFFF_FFFF, 32'hABCD_0064, 5'h10, 16'd0, 32'hFFFF_F9C0);
    run_write("R7 mul imm5 pos", 4'd6, 32'h0, 32'h0000_FFFD, 5'h07, 16'd0, 32'hFFFF_FFEB);
    run_write("R8 mul imm16 neg", 4'd7, 32'h5555_0003, 32'hFFFF_FFFF, 5'd0, 16'h8000, 32'hFFFE_8000);
    run_write("R8 mul imm16 both neg", 4'd7, 32'h0000_FFFF, 32'd0, 5'd0, 16'hFFFF, 32'h0000_0001);
  endtask

  task automatic t_logic;
    run_logic("R9 not to zero", 4'd8, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_0000);
    run_logic("R9 not to neg", 4'd8, 32'h0000_0000, 32'd0, 32'hFFFF_FFFF);
    run_logic("R9 or neg", 4'd9, 32'h8000_0000, 32'h0000_0001, 32'h8000_0001);
    run_write("R10 mul keeps flags", 4'd5, 32'h0000_0000, 32'h0000_0005, 5'd0, 16'd0, 32'h0);
    run_logic("R9 or zero", 4'd9, 32'h0, 32'h0, 32'h0000_0000);
    run_logic("R9 or pos", 4'd9, 32'h0F0F_0000, 32'h0000_00F0, 32'h0F0F_00F0);
    run_write("R10 addr keeps flags", 4'd3, 32'h8000_0000, 32'd0, 5'd0, 16'h0000, 32'h8000_0000);
  endtask

  task automatic t_nop;
    for (int c = 0; c < 16; c++) begin
      if (c == 0 || c >= 10) begin
        issue(c[3:0], 32'hCAFE_F00D, 32'h1234_5678, 5'h1F, 16'hFFFF);
        chk($sformatf("R11 code %0d result", c), result_o, last_res);
        chk($sformatf("R11 code %0d strobes", c), {29'd0, valid_o, rd_we_o, flag_we_o},
            {29'd0, 1'b1, 1'b0, 1'b0});
        chk_flags($sformatf("R11 code %0d flags", c), exp_ov, exp_s, exp_z);
      end
    end
  endtask

  task automatic t_idle;
    run_logic("R12 setup", 4'd9, 32'h8000_0000, 32'h0, 32'h8000_0000);
    @(negedge clk);
    op_i = 4'd9; src1_i = 32'h0; src2_i = 32'h0;
    @(negedge clk);
    chk("R12 result held", result_o, last_res);
    chk("R12 strobes low", {29'd0, valid_o, rd_we_o, flag_we_o}, 32'd0);
    chk_flags("R12 flags held", exp_ov, exp_s, exp_z);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_moves();
    t_adds();
    t_muls();
    t_logic();
    t_nop();
    t_idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule